// File: doc/BRIEF.md
# Per-Endpoint DMA Enable Control

This block holds one DMA enable bit for each of 32 logical endpoints of a USB device controller and tells the DMA engine where it may start a packet. Software reads the enable word at a read-only address. It sets bits through a write-1-to-set port and clears them through a write-1-to-clear port. The two control endpoints (positions 0 and 1) can never be enabled.

A busy latch per endpoint tracks a packet that the DMA engine has started. A disable therefore takes effect only at the packet boundary: the engine may carry on with the current packet while the endpoint is busy. An error strobe from the engine clears both the enable and the busy latch at once.

The block also keeps a single proceed flag. The engine sets it with a strobe, software reads it at a spare address, and a disable write of all zeros clears it.

Top module: `epDmaCtrl`

## Requirements
- R1: Reading address 0 returns the enable word, bit n for endpoint n. Every bit is 0 after reset.
- R2: A bus write to address 0 or address 3 changes no state.
- R3: A write to address 1 sets each enable bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A write to address 2 clears each enable bit whose data bit is 1 and leaves the other bits unchanged.
- R5: Enable bits 0 and 1 always read 0, even after a write of 1 to those positions at address 1.
- R6: `mayStart` equals the enable word. A `pktStart` bit marks the endpoint busy only while its enable bit is 1.
- R7: `mayContinue` equals the enable word OR the busy latch. A busy latch clears on `pktEnd`. A start and an end in the same cycle leave the endpoint busy.
- R8: A `pktErr` bit clears the enable bit and the busy latch of its endpoint in the next cycle. It wins over an enable write to the same bit in the same cycle.
- R9: `proceedSet` sets the proceed flag, which reads at address 3 bit 0 with all other bits 0. A write of all zeros to address 2 clears the flag, and this clear wins over a set in the same cycle.
- R10: Reads of addresses 1 and 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| pktStart | input | 32 | Per-endpoint packet start strobe from the DMA engine |
| pktEnd | input | 32 | Per-endpoint packet end strobe |
| pktErr | input | 32 | Per-endpoint error strobe |
| proceedSet | input | 1 | Sets the proceed flag |
| mayStart | output | 32 | Endpoint may start a new packet |
| mayContinue | output | 32 | Endpoint may carry on with the packet in progress |

## Verification
The hardest situation to reach is an endpoint that has been disabled by software while its busy latch is still set. It must keep `mayContinue` high and `mayStart` low until the end strobe arrives. Directed sequences build this case: an enable, then a start, then a disable, then an end. They also collide an error with an enable of the same bit in one cycle. The random phase weights starts toward enabled endpoints and ends toward busy ones, so that packet lifetimes overlap enable and disable writes often.

// File: rtl/epDmaPkg.sv
package epDmaPkg;
  localparam logic [1:0] ADDR_STATUS  = 2'd0;
  localparam logic [1:0] ADDR_SET     = 2'd1;
  localparam logic [1:0] ADDR_CLR     = 2'd2;
  localparam logic [1:0] ADDR_PROCEED = 2'd3;

  typedef struct packed {
    logic doSet;
    logic doClr;
    logic clrProceed;
  } ctrlStrobe_t;
endpackage

// File: rtl/epDmaCtrlDecode.sv
module epDmaCtrlDecode
  import epDmaPkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [NUM_EP-1:0] regWrData,
  output ctrlStrobe_t       strobe
);
  logic wrSet;
  logic wrClr;

  always_comb begin
    wrSet = regWrEn && (regAddr == ADDR_SET);
    wrClr = regWrEn && (regAddr == ADDR_CLR);
    strobe.doSet      = wrSet;
    strobe.doClr      = wrClr;
    strobe.clrProceed = wrClr && (regWrData == '0);
  end
endmodule

// File: rtl/epDmaDatapath.sv
module epDmaDatapath
  import epDmaPkg::*;
#(
  parameter int NUM_EP   = 32,
  parameter int NUM_CTRL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [NUM_EP-1:0] wrData,
  input  logic [1:0]        rdAddr,
  input  logic [NUM_EP-1:0] pktStart,
  input  logic [NUM_EP-1:0] pktEnd,
  input  logic [NUM_EP-1:0] pktErr,
  input  logic              proceedSet,
  output logic [NUM_EP-1:0] rdData,
  output logic [NUM_EP-1:0] enWord,
  output logic [NUM_EP-1:0] busyWord
);
  logic proceedQ;

  for (genvar ep = 0; ep < NUM_EP; ep++) begin : g_ep
    if (ep < NUM_CTRL) begin : g_ctrl
      assign enWord[ep]   = 1'b0;
      assign busyWord[ep] = 1'b0;
    end else begin : g_data
      logic enQ;
      logic busyQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          enQ   <= 1'b0;
          busyQ <= 1'b0;
        end else begin
          if (pktErr[ep])
            enQ <= 1'b0;
          else if (strobe.doSet && wrData[ep])
            enQ <= 1'b1;
          else if (strobe.doClr && wrData[ep])
            enQ <= 1'b0;

          if (pktErr[ep])
            busyQ <= 1'b0;
          else if (pktStart[ep] && enQ)
            busyQ <= 1'b1;
          else if (pktEnd[ep])
            busyQ <= 1'b0;
        end
      end
      assign enWord[ep]   = enQ;
      assign busyWord[ep] = busyQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      proceedQ <= 1'b0;
    else if (strobe.clrProceed)
      proceedQ <= 1'b0;
    else if (proceedSet)
      proceedQ <= 1'b1;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_STATUS:  rdData = enWord;
      ADDR_PROCEED: rdData = {{(NUM_EP-1){1'b0}}, proceedQ};
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/epDmaCtrl.sv
module epDmaCtrl
  import epDmaPkg::*;
#(
  parameter int NUM_EP   = 32,
  parameter int NUM_CTRL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [NUM_EP-1:0] regWrData,
  output logic [NUM_EP-1:0] regRdData,
  input  logic [NUM_EP-1:0] pktStart,
  input  logic [NUM_EP-1:0] pktEnd,
  input  logic [NUM_EP-1:0] pktErr,
  input  logic              proceedSet,
  output logic [NUM_EP-1:0] mayStart,
  output logic [NUM_EP-1:0] mayContinue
);
  ctrlStrobe_t       strobe;
  logic [NUM_EP-1:0] enWord;
  logic [NUM_EP-1:0] busyWord;

  epDmaCtrlDecode #(.NUM_EP(NUM_EP)) u_decode (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  epDmaDatapath #(.NUM_EP(NUM_EP), .NUM_CTRL(NUM_CTRL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .pktStart  (pktStart),
    .pktEnd    (pktEnd),
    .pktErr    (pktErr),
    .proceedSet(proceedSet),
    .rdData    (regRdData),
    .enWord    (enWord),
    .busyWord  (busyWord)
  );

  assign mayStart    = enWord;
  assign mayContinue = enWord | busyWord;
endmodule

// File: rtl/epDmaCtrlChecker.sv
module epDmaCtrlChecker
  import epDmaPkg::*;
#(
  parameter int NUM_EP = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [NUM_EP-1:0] regWrData,
  input logic [NUM_EP-1:0] pktErr,
  input logic [NUM_EP-1:0] mayStart,
  input logic [NUM_EP-1:0] mayContinue
);
  // R5: control endpoints never enabled
  p_ctrl_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    mayStart[1:0] == 2'b00);

  // R8: an error clears the enable bit in the next cycle
  p_err_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|pktErr) |=> ((mayStart & $past(pktErr)) == '0));

  // R4: disable write clears the written bits
  p_clr_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CLR) |=> ((mayStart & $past(regWrData)) == '0));

  // R3: an enable bit rises only through a set write with that bit at 1
  p_rise_by_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((mayStart & ~$past(mayStart)) != '0) |->
      ($past(regWrEn) && $past(regAddr) == ADDR_SET &&
       ((mayStart & ~$past(mayStart) & ~$past(regWrData)) == '0)));

  // R7: continue permission never appears without start permission
  p_cont_needs_en_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((mayContinue & ~$past(mayContinue) & ~mayStart) == '0));
endmodule

bind epDmaCtrl epDmaCtrlChecker #(.NUM_EP(NUM_EP)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .pktErr     (pktErr),
  .mayStart   (mayStart),
  .mayContinue(mayContinue)
);

// File: tb/sim_epDmaCtrl.sv
`timescale 1ns/1ps
module sim_epDmaCtrl;
  localparam int NEP = 32;
  localparam logic [NEP-1:0] KEEP = ~32'h3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [1:0]     regAddr = '0;
  logic           regWrEn = 1'b0;
  logic [NEP-1:0] regWrData = '0;
  logic [NEP-1:0] regRdData;
  logic [NEP-1:0] pktStart = '0, pktEnd = '0, pktErr = '0;
  logic           proceedSet = 1'b0;
  logic [NEP-1:0] mayStart, mayContinue;

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [NEP-1:0] mEn = '0, mBusy = '0;
  logic           mProc = 1'b0;

  always #2.5 clk = ~clk;

  epDmaCtrl u0 (.*);

  task automatic check(string req, logic [NEP-1:0] act, logic [NEP-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NEP-1:0] expRead(logic [1:0] a);
    case (a)
      2'd0:    return mEn;
      2'd3:    return {{(NEP-1){1'b0}}, mProc};
      default: return '0;
    endcase
  endfunction

  // at negedge: drive, check read, advance model, wait one cycle, check outputs
  task automatic step(logic [1:0] a, logic w, logic [NEP-1:0] d, logic [NEP-1:0] st,
                      logic [NEP-1:0] en, logic [NEP-1:0] er, logic ps);
    logic [NEP-1:0] nEn, nBusy;
    regAddr = a; regWrEn = w; regWrData = d;
    pktStart = st; pktEnd = en; pktErr = er; proceedSet = ps;
    #1;
    check(a == 2'd0 ? "R1 read" : a == 2'd3 ? "R9 read" : "R10 read", regRdData, expRead(a));
    nEn = mEn;
    if (w && a == 2'd1) nEn = nEn | (d & KEEP);
    if (w && a == 2'd2) nEn = nEn & ~d;
    nEn = nEn & ~er;
    nBusy = ((mBusy & ~en) | (st & mEn)) & ~er;
    if (w && a == 2'd2 && d == '0) mProc = 1'b0;
    else if (ps) mProc = 1'b1;
    mEn = nEn; mBusy = nBusy;
    @(posedge clk); @(negedge clk);
    check("R6 mayStart", mayStart, mEn);
    check("R7 mayContinue", mayContinue, mEn | mBusy);
  endtask

  task automatic idle();
    step(2'd0, 1'b0, '0, '0, '0, '0, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 reset word", regRdData, '0);
    check("R1 reset mayStart", mayStart, '0);
    // R3 / R5: enable incl. control positions
    step(2'd1, 1'b1, 32'h8000_00F7, '0, '0, '0, 1'b0);
    check("R5 ctrl bits", {30'd0, mayStart[1:0]}, '0);
    step(2'd1, 1'b1, 32'h0000_0100, '0, '0, '0, 1'b0);
    check("R3 keep others", mayStart, 32'h8000_01F4);
    // R2: writes to status and proceed addresses ignored
    step(2'd0, 1'b1, '0, '0, '0, '0, 1'b0);
    step(2'd3, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, 1'b0);
    check("R2 no effect", mayStart, 32'h8000_01F4);
    // R7: disable mid-packet
    step(2'd0, 1'b0, '0, 32'h0000_0010, '0, '0, 1'b0);
    step(2'd2, 1'b1, 32'h0000_0010, '0, '0, '0, 1'b0);
    check("R4 disabled", mayStart[4], 1'b0);
    check("R7 still continue", mayContinue[4], 1'b1);
    step(2'd0, 1'b0, '0, '0, 32'h0000_0010, '0, 1'b0);
    check("R7 ended", mayContinue[4], 1'b0);
    // R6: start on disabled endpoint ignored
    step(2'd0, 1'b0, '0, 32'h0000_0200, '0, '0, 1'b0);
    check("R6 no busy", mayContinue[9], 1'b0);
    // R8: error wins over enable
    step(2'd1, 1'b1, 32'h0000_0020, 32'h0000_0004, '0, 32'h0000_0020, 1'b0);
    check("R8 err wins", mayStart[5], 1'b0);
    step(2'd0, 1'b0, '0, '0, '0, 32'h0000_0004, 1'b0);
    check("R8 busy cleared", mayContinue[2], 1'b0);
    // R9: proceed flag
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b1);
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b0);
    step(2'd2, 1'b1, '0, '0, '0, '0, 1'b1);
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b0);
    idle();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a; logic w; logic [NEP-1:0] d, st, en, er;
      a = 2'($urandom_range(0, 3));
      w = ($urandom_range(0, 2) != 0);
      d = $urandom() & $urandom();
      if ($urandom_range(0, 5) == 0) d = '0;
      st = $urandom() & (mEn | $urandom());
      en = $urandom() & mBusy;
      er = ($urandom_range(0, 7) == 0) ? (NEP'(1) << $urandom_range(0, NEP-1)) : '0;
      step(a, w, d, st, en, er, ($urandom_range(0, 3) == 0));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule